// File: doc/BRIEF.md
# Load-Link Reservation Monitor

This block keeps the single reservation that a processor core needs to carry out atomic read-modify-write sequences with a load-link and store-conditional pair. A load-link records which aligned region of memory (a granule) holds the target word and marks the reservation as live. From then on the block compares every write seen from other agents against that granule. A write that lands anywhere inside the granule ends the reservation, even if it misses the exact word. Interrupt or exception entry also ends it.

A store-conditional is judged in the cycle it is presented. The answer appears one cycle later on a registered response pair. The reservation is always dropped after a store-conditional, so software that fails simply loops back to a new load-link. The granule size is a power-of-two parameter that ranges from the word size up to 2048 bytes. The memory write itself, caches, the bus fabric and the arithmetic all live outside this block.

The controller has two states. `RSV_IDLE` means no reservation is held. `RSV_HELD` means a granule tag is stored and live. Its transitions are:
- arm: `RSV_IDLE` to `RSV_HELD` on a load-link with no interrupt clear.
- re-arm: `RSV_HELD` to `RSV_HELD` on a load-link with no interrupt clear. The tag is replaced.
- flush: any state to `RSV_IDLE` on an interrupt clear.
- consume: `RSV_HELD` to `RSV_IDLE` on a store-conditional without a load-link.
- kill: `RSV_HELD` to `RSV_IDLE` on a snooped write to the reserved granule without a load-link.

Top module: `resv_monitor`

## Requirements
- R1: After synchronous reset, `sc_resp_valid` and `sc_success` are 0 and no reservation is held, so a first store-conditional reports failure.
- R2: A store-conditional whose address lies in the held granule, with no interfering event, reports success. `sc_resp_valid` is 1 and `sc_success` is 1 in the cycle after the request, and `sc_resp_valid` is 0 after a cycle with no request.
- R3: A snooped write to any byte of the reserved granule (same address bits above log2(GRAN_BYTES)) ends the reservation. A snooped write outside the granule leaves it intact.
- R4: Every store-conditional ends the reservation, whether it passes or fails. A second store-conditional without a new load-link fails.
- R5: A store-conditional to a granule other than the reserved one fails and ends the reservation.
- R6: `irq_clear` ends the reservation. When it comes in the same cycle as a load-link, no reservation is held afterwards.
- R7: When a snooped write to the reserved granule and a store-conditional come in the same cycle, the store-conditional fails.
- R8: A new load-link replaces the earlier reservation. A store-conditional to the old granule then fails, and one to the new granule passes.
- R9: When a store-conditional and `irq_clear` come in the same cycle, the store-conditional fails.
- R10: When a store-conditional and a load-link come in the same cycle, the store-conditional is judged against the reservation held before that cycle, and the load-link's reservation is held afterwards.
- R11: A snooped write in the same cycle as a load-link does not cancel the new reservation, even if it hits the new granule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ll_valid | input | 1 | Load-link request |
| ll_addr | input | ADDR_W | Load-link byte address |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | ADDR_W | Store-conditional byte address |
| snoop_wr_valid | input | 1 | Write from another agent observed |
| snoop_wr_addr | input | ADDR_W | Byte address of that write |
| irq_clear | input | 1 | Interrupt or exception entry, ends reservation |
| sc_resp_valid | output | 1 | Registered: a store-conditional was judged last cycle |
| sc_success | output | 1 | Registered: that store-conditional passed |

## Verification
Several pairs of events can fall in the same cycle: a store-conditional with a snooped write, with `irq_clear`, or with a new load-link, and a load-link with `irq_clear` or with a snooped write. Each pair is driven as one input vector on a single clock edge. The pass or fail answer and the state left behind are then judged with follow-up store-conditionals, against outcomes worked out from granule arithmetic on the addresses. Granule hits and misses are swept across offsets on both sides of the reserved granule's edges.

// File: rtl/resv_pkg.sv
package resv_pkg;
    typedef enum logic {
        RSV_IDLE = 1'b0,
        RSV_HELD = 1'b1
    } resv_state_e;
endpackage

// File: rtl/resv_gran_cmp.sv
module resv_gran_cmp #(
    parameter int ADDR_W   = 32,
    parameter int GRAN_LSB = 6
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [ADDR_W-GRAN_LSB-1:0] tag,
    output logic                       hit
);
    localparam int TAG_W = ADDR_W - GRAN_LSB;

    logic [TAG_W-1:0] addr_tag;

    always_comb begin
        addr_tag = addr[ADDR_W-1:GRAN_LSB];
        hit      = (addr_tag == tag);
    end
endmodule

// File: rtl/resv_fsm.sv
module resv_fsm
    import resv_pkg::*;
#(
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ll_valid,
    input  logic [TAG_W-1:0] ll_tag,
    input  logic             sc_valid,
    input  logic             snoop_hit,
    input  logic             irq_clear,
    output logic             held,
    output logic [TAG_W-1:0] tag_q
);
    resv_state_e      state, state_nxt;
    logic [TAG_W-1:0] tag_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RSV_IDLE;
            tag_q <= '0;
        end else begin
            state <= state_nxt;
            tag_q <= tag_nxt;
        end
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        tag_nxt   = tag_q;
        unique case (state)
            RSV_IDLE: begin
                if (ll_valid && !irq_clear) begin
                    state_nxt = RSV_HELD;   // arm
                    tag_nxt   = ll_tag;
                end
            end
            RSV_HELD: begin
                if (irq_clear) begin
                    state_nxt = RSV_IDLE;   // flush
                end else if (ll_valid) begin
                    state_nxt = RSV_HELD;   // re-arm
                    tag_nxt   = ll_tag;
                end else if (sc_valid || snoop_hit) begin
                    state_nxt = RSV_IDLE;   // consume or kill
                end
            end
            default: state_nxt = RSV_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        held = (state == RSV_HELD);
    end

    assert_irq_clears_R6: assert property (@(posedge clk) disable iff (rst)
        irq_clear |=> state == RSV_IDLE);

    assert_sc_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && !ll_valid) |=> state == RSV_IDLE);

    assert_snoop_kills_R3: assert property (@(posedge clk) disable iff (rst)
        (held && snoop_hit && !ll_valid) |=> state == RSV_IDLE);

    assert_ll_arms_R8: assert property (@(posedge clk) disable iff (rst)
        (ll_valid && !irq_clear) |=> (state == RSV_HELD && tag_q == $past(ll_tag)));
endmodule

// File: rtl/resv_resp.sv
module resv_resp (
    input  logic clk,
    input  logic rst,
    input  logic sc_valid,
    input  logic sc_pass,
    output logic sc_resp_valid,
    output logic sc_success
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sc_resp_valid <= 1'b0;
            sc_success    <= 1'b0;
        end else begin
            sc_resp_valid <= sc_valid;
            sc_success    <= sc_valid && sc_pass;
        end
    end

    assert_pass_has_resp_R2: assert property (@(posedge clk) disable iff (rst)
        sc_success |-> sc_resp_valid);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ll_valid,
    input  logic [ADDR_W-1:0] ll_addr,
    input  logic              sc_valid,
    input  logic [ADDR_W-1:0] sc_addr,
    input  logic              snoop_wr_valid,
    input  logic [ADDR_W-1:0] snoop_wr_addr,
    input  logic              irq_clear,
    output logic              sc_resp_valid,
    output logic              sc_success
);
    localparam int GRAN_LSB = $clog2(GRAN_BYTES);
    localparam int TAG_W    = ADDR_W - GRAN_LSB;
    localparam int N_PROBE  = 2;   // 0: snooped write, 1: store-conditional

    logic [TAG_W-1:0]  tag_q;
    logic [TAG_W-1:0]  ll_tag;
    logic              held;
    logic [ADDR_W-1:0] probe_addr [N_PROBE];
    logic [N_PROBE-1:0] probe_hit;
    logic              snoop_hit;
    logic              sc_pass;

    always_comb begin
        ll_tag        = ll_addr[ADDR_W-1:GRAN_LSB];
        probe_addr[0] = snoop_wr_addr;
        probe_addr[1] = sc_addr;
    end

    for (genvar p = 0; p < N_PROBE; p++) begin : g_probe
        resv_gran_cmp #(
            .ADDR_W  (ADDR_W),
            .GRAN_LSB(GRAN_LSB)
        ) u_cmp (
            .addr(probe_addr[p]),
            .tag (tag_q),
            .hit (probe_hit[p])
        );
    end

    always_comb begin
        snoop_hit = snoop_wr_valid && probe_hit[0];
        sc_pass   = held && probe_hit[1] && !snoop_hit && !irq_clear;
    end

    resv_fsm #(.TAG_W(TAG_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ll_valid (ll_valid),
        .ll_tag   (ll_tag),
        .sc_valid (sc_valid),
        .snoop_hit(snoop_hit),
        .irq_clear(irq_clear),
        .held     (held),
        .tag_q    (tag_q)
    );

    resv_resp u_resp (
        .clk          (clk),
        .rst          (rst),
        .sc_valid     (sc_valid),
        .sc_pass      (sc_pass),
        .sc_resp_valid(sc_resp_valid),
        .sc_success   (sc_success)
    );

    assert_collision_fails_R7: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && snoop_wr_valid && probe_hit[0]) |=> !sc_success);

    assert_irq_blocks_sc_R9: assert property (@(posedge clk) disable iff (rst)
        (sc_valid && irq_clear) |=> !sc_success);

    assert_pass_needs_resv_R2: assert property (@(posedge clk) disable iff (rst)
        sc_success |-> $past(held));
endmodule

// File: tb/resv_monitor_test.sv
module resv_monitor_test;
    localparam int AW = 12;
    localparam int GB = 16;
    localparam int GL = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ll_valid = 1'b0, sc_valid = 1'b0, snoop_wr_valid = 1'b0, irq_clear = 1'b0;
    logic [AW-1:0] ll_addr = '0, sc_addr = '0, snoop_wr_addr = '0;
    logic          sc_resp_valid, sc_success;

    int vecs = 0;
    int errs = 0;
    bit done = 0;

    always #4 clk = ~clk;

    resv_monitor #(.ADDR_W(AW), .GRAN_BYTES(GB)) uut (
        .clk(clk), .rst(rst),
        .ll_valid(ll_valid), .ll_addr(ll_addr),
        .sc_valid(sc_valid), .sc_addr(sc_addr),
        .snoop_wr_valid(snoop_wr_valid), .snoop_wr_addr(snoop_wr_addr),
        .irq_clear(irq_clear),
        .sc_resp_valid(sc_resp_valid), .sc_success(sc_success)
    );

    function automatic logic same_gran(input logic [AW-1:0] a, input logic [AW-1:0] b);
        return (a >> GL) == (b >> GL);
    endfunction

    task automatic cyc(input logic l, input logic [AW-1:0] la,
                       input logic s, input logic [AW-1:0] sa,
                       input logic w, input logic [AW-1:0] wa,
                       input logic q);
        @(negedge clk);
        ll_valid = l; ll_addr = la;
        sc_valid = s; sc_addr = sa;
        snoop_wr_valid = w; snoop_wr_addr = wa;
        irq_clear = q;
        @(posedge clk);
        #1;
        ll_valid = 0; sc_valid = 0; snoop_wr_valid = 0; irq_clear = 0;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic ll(input logic [AW-1:0] a);
        cyc(1, a, 0, '0, 0, '0, 0);
    endtask

    task automatic sc_chk(input logic [AW-1:0] a, input logic exp, input string tag);
        cyc(0, '0, 1, a, 0, '0, 0);
        chk(sc_resp_valid, 1'b1, tag);
        chk(sc_success, exp, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] base;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1 reset state
        chk(sc_resp_valid, 1'b0, "R1 resp_valid after reset");
        chk(sc_success, 1'b0, "R1 success after reset");
        sc_chk(12'h000, 1'b0, "R1 first sc fails");

        // R2 every byte of the granule passes; idle cycle drops resp_valid
        for (int b = 0; b < GB; b++) begin
            ll(12'h230);
            sc_chk(12'h230 | 12'(b), 1'b1, "R2 sc in granule");
        end
        cyc(0, '0, 0, '0, 0, '0, 0);
        chk(sc_resp_valid, 1'b0, "R2 no request no resp");

        // R3 snoop offset sweep across granule edges
        for (int k = 0; k < 2; k++) begin
            base = (k == 0) ? 12'h104 : 12'h7F8;
            for (int off = -32; off <= 32; off += 4) begin
                logic [AW-1:0] wa;
                wa = base + 12'(off);
                ll(base);
                cyc(0, '0, 0, '0, 1, wa, 0);
                sc_chk(base, !same_gran(base, wa), "R3 snoop sweep");
            end
        end

        // R4 second sc fails
        ll(12'h400);
        sc_chk(12'h404, 1'b1, "R4 first sc");
        sc_chk(12'h404, 1'b0, "R4 second sc");
        ll(12'h400);
        sc_chk(12'h500, 1'b0, "R4 failing sc");
        sc_chk(12'h400, 1'b0, "R4 after failing sc");

        // R5 sc address sweep
        for (int i = 0; i < 64; i++) begin
            logic [AW-1:0] sa;
            sa = 12'(i * 64) | 12'h008;
            ll(12'h648);
            sc_chk(sa, same_gran(sa, 12'h648), "R5 sc granule sweep");
            sc_chk(12'h648, 1'b0, "R5 cleared after sweep sc");
        end
        ll(12'h648);
        sc_chk(12'h658, 1'b0, "R5 adjacent granule");

        // R6 irq clear
        ll(12'h300);
        cyc(0, '0, 0, '0, 0, '0, 1);
        sc_chk(12'h300, 1'b0, "R6 irq flush");
        ll(12'h300);
        cyc(1, 12'h300, 0, '0, 0, '0, 1);
        sc_chk(12'h300, 1'b0, "R6 ll with irq");

        // R7 collision
        ll(12'h520);
        cyc(0, '0, 1, 12'h520, 1, 12'h52C, 0);
        chk(sc_resp_valid, 1'b1, "R7 collision resp");
        chk(sc_success, 1'b0, "R7 collision fails");
        ll(12'h520);
        cyc(0, '0, 1, 12'h520, 1, 12'h530, 0);
        chk(sc_success, 1'b1, "R7 snoop elsewhere passes");

        // R8 replacement
        ll(12'h100);
        ll(12'h200);
        sc_chk(12'h100, 1'b0, "R8 old granule fails");
        ll(12'h100);
        ll(12'h200);
        sc_chk(12'h200, 1'b1, "R8 new granule passes");

        // R9 sc with irq
        ll(12'h340);
        cyc(0, '0, 1, 12'h340, 0, '0, 1);
        chk(sc_resp_valid, 1'b1, "R9 resp");
        chk(sc_success, 1'b0, "R9 sc with irq fails");
        sc_chk(12'h340, 1'b0, "R9 reservation gone");

        // R10 sc and ll together
        ll(12'h700);
        cyc(1, 12'h800, 1, 12'h700, 0, '0, 0);
        chk(sc_success, 1'b1, "R10 judged on old");
        sc_chk(12'h800, 1'b1, "R10 new held");
        cyc(1, 12'h900, 1, 12'h900, 0, '0, 0);
        chk(sc_success, 1'b0, "R10 idle sc with ll fails");
        sc_chk(12'h900, 1'b1, "R10 ll armed from idle");

        // R11 snoop with ll
        cyc(1, 12'hA00, 0, '0, 1, 12'hA04, 0);
        sc_chk(12'hA00, 1'b1, "R11 ll survives snoop");
        ll(12'hA00);
        cyc(1, 12'hB00, 0, '0, 1, 12'hB00, 0);
        sc_chk(12'hB00, 1'b1, "R11 re-arm survives snoop");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule